// File: doc/BRIEF.md
# Event Binning Occupancy History

This block turns a stream of camera events into a one-dimensional binary record of where motion happened over recent time. Each event carries a position along the estimated axis. The orthogonal coordinate is not wired in, so the collapse along that axis happens at the port boundary. A free-running timer cuts time into bins of fixed length. During a bin, one saturating 8-bit counter per position counts the events that land on it.

When a bin closes, every counter is compared with a threshold, which gives one occupancy bit per position. The counters are then cleared. The occupancy vector is pushed into a bank of per-position shift registers, one bit per bin. A downstream motion scorer reads the whole bank in parallel after the history-valid strobe, and the bank then holds still until the next bin closes.

Top module: `evt_occ_history`

## Requirements
- R1: `bin_done` is a one-cycle pulse. It first goes high BIN_CYCLES cycles after reset is released and then once every BIN_CYCLES cycles.
- R2: A valid event increments only the counter of the position given on `ev_pos`. Each position keeps its own count.
- R3: At a bin boundary, the occupancy bit of a position is 1 exactly when its count for that bin is at least THETA_E (default 3).
- R4: Counts do not carry across bins. Two events at one position in each of two bins give occupancy 0 in both bins.
- R5: `history[i*DEPTH + k]` is bit k of the row for position i, where bit 0 is the newest bin. Each bin shifts every row left by one and drops its oldest bit.
- R6: An event counter saturates at 255 and does not wrap. 256 events in one bin give occupancy 1.
- R7: An event seen in the cycle that closes a bin, or in either of the two following processing cycles, is counted in the next bin and is not lost.
- R8: An event whose position is NX or greater changes no counter and no history bit.
- R9: `history_valid` pulses for one cycle, two cycles after `bin_done`. `history` changes only in the cycle where `history_valid` is high.
- R10: While reset is held, `history` is all zero and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event strobe, one event per cycle |
| ev_pos | input | XW | Event position on the estimated axis |
| bin_done | output | 1 | Pulse marking the close of a bin |
| history_valid | output | 1 | Pulse when the bank holds a newly shifted column |
| history | output | NX*DEPTH | Occupancy history bank, row i at bits i*DEPTH upward |

## Verification
The hardest case to reach from the ports is an event that arrives in the exact cycle that closes a bin, or in the two processing cycles after it. Those events must go to the next bin and must still combine with its other events. The stimulus counts clock edges from the release of reset and aligns events to chosen offsets inside the bin. It places hits on both sides of the boundary so that the bin before it stays below threshold and the bin after it reaches threshold only if no hit is lost. Saturation is reached with 256 back-to-back hits on one position, where a wrapping counter would read zero.

// File: rtl/evt_occ_pkg.sv
package evt_occ_pkg;

  // Control sequence per bin: count, compare, push into the bank.
  typedef enum logic [1:0] {
    ST_ACC = 2'd0,
    ST_THR = 2'd1,
    ST_SHF = 2'd2
  } bin_state_e;

endpackage

// File: rtl/evt_bin_timer.sv
module evt_bin_timer #(
  parameter int BIN_CYCLES = 320
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  localparam int TW = $clog2(BIN_CYCLES);
  localparam logic [TW-1:0] LAST = TW'(BIN_CYCLES - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = (cnt_q == LAST);

endmodule

// File: rtl/evt_cnt_bank.sv
module evt_cnt_bank #(
  parameter int NX      = 16,
  parameter int XW      = 8,
  parameter int CNT_W   = 8,
  parameter int THETA_E = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_valid,
  input  logic [XW-1:0] ev_pos,
  input  logic          acc_en,   // normal counting
  input  logic          hold_en,  // bin-closing cycle: park the event
  input  logic          load_en,  // compare cycle: restart counters
  output logic [NX-1:0] occ
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] THR     = CNT_W'(THETA_E);

  logic          pend_v_q;
  logic [XW-1:0] pend_pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v_q   <= 1'b0;
      pend_pos_q <= '0;
    end else begin
      pend_v_q <= hold_en & ev_valid;
      if (hold_en) begin
        pend_pos_q <= ev_pos;
      end
    end
  end

  for (genvar i = 0; i < NX; i++) begin : g_pos
    logic             hit;
    logic             phit;
    logic [CNT_W-1:0] cnt_q;

    assign hit  = ev_valid && (ev_pos == XW'(i));
    assign phit = pend_v_q && (pend_pos_q == XW'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q <= '0;
      end else if (load_en) begin
        cnt_q <= CNT_W'(phit) + CNT_W'(hit);
      end else if (acc_en && hit && (cnt_q != CNT_MAX)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end

    assign occ[i] = (cnt_q >= THR);
  end

endmodule

// File: rtl/evt_hist_bank.sv
module evt_hist_bank #(
  parameter int NX    = 16,
  parameter int DEPTH = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shift_en,
  input  logic [NX-1:0]       occ_in,
  output logic [NX*DEPTH-1:0] hist
);

  for (genvar i = 0; i < NX; i++) begin : g_row
    logic [DEPTH-1:0] row_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        row_q <= '0;
      end else if (shift_en) begin
        row_q <= {row_q[DEPTH-2:0], occ_in[i]};
      end
    end

    assign hist[i*DEPTH +: DEPTH] = row_q;
  end

endmodule

// File: rtl/evt_occ_history.sv
module evt_occ_history #(
  parameter int NX         = 16,
  parameter int XW         = 8,
  parameter int DEPTH      = 8,
  parameter int CNT_W      = 8,
  parameter int THETA_E    = 3,
  parameter int BIN_CYCLES = 320
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ev_valid,
  input  logic [XW-1:0]       ev_pos,
  output logic                bin_done,
  output logic                history_valid,
  output logic [NX*DEPTH-1:0] history
);

  import evt_occ_pkg::*;

  bin_state_e    state_q;
  logic          tick;
  logic [NX-1:0] occ_now;
  logic [NX-1:0] occ_q;
  logic          bin_done_q;
  logic          hv_q;
  logic          acc_en;
  logic          load_en;
  logic          shift_en;

  evt_bin_timer #(.BIN_CYCLES(BIN_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  assign load_en  = (state_q == ST_THR);
  assign shift_en = (state_q == ST_SHF);
  assign acc_en   = !load_en && !tick;

  evt_cnt_bank #(
    .NX(NX), .XW(XW), .CNT_W(CNT_W), .THETA_E(THETA_E)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .ev_valid (ev_valid),
    .ev_pos   (ev_pos),
    .acc_en   (acc_en),
    .hold_en  (tick),
    .load_en  (load_en),
    .occ      (occ_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_ACC;
      occ_q      <= '0;
      bin_done_q <= 1'b0;
      hv_q       <= 1'b0;
    end else begin
      bin_done_q <= tick;
      hv_q       <= shift_en;
      unique case (state_q)
        ST_ACC:  if (tick) state_q <= ST_THR;
        ST_THR: begin
          occ_q   <= occ_now;
          state_q <= ST_SHF;
        end
        ST_SHF:  state_q <= ST_ACC;
        default: state_q <= ST_ACC;
      endcase
    end
  end

  evt_hist_bank #(.NX(NX), .DEPTH(DEPTH)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .occ_in   (occ_q),
    .hist     (history)
  );

  assign bin_done      = bin_done_q;
  assign history_valid = hv_q;

endmodule

// File: rtl/evt_occ_history_chk.sv
module evt_occ_history_chk #(
  parameter int NX         = 16,
  parameter int DEPTH      = 8,
  parameter int BIN_CYCLES = 320
) (
  input logic                clk,
  input logic                rst,
  input logic                bin_done,
  input logic                history_valid,
  input logic [NX*DEPTH-1:0] history
);

  logic [31:0] since_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= '0;
    end else if (bin_done) begin
      since_q <= 32'd1;
    end else begin
      since_q <= since_q + 32'd1;
    end
  end

  // R1
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    bin_done |=> !bin_done);
  p_done_period_r1: assert property (@(posedge clk) disable iff (rst)
    bin_done |-> (since_q == 32'(BIN_CYCLES)));
  p_done_due_r1: assert property (@(posedge clk) disable iff (rst)
    (since_q == 32'(BIN_CYCLES)) |-> bin_done);

  // R9
  p_valid_after_done_r9: assert property (@(posedge clk) disable iff (rst)
    bin_done |-> ##2 history_valid);
  p_valid_cause_r9: assert property (@(posedge clk) disable iff (rst)
    history_valid |-> $past(bin_done, 2));
  p_hist_stable_r9: assert property (@(posedge clk) disable iff (rst)
    !history_valid |-> $stable(history));

  // R5
  for (genvar i = 0; i < NX; i++) begin : g_row_chk
    p_row_shift_r5: assert property (@(posedge clk) disable iff (rst)
      history_valid |->
        (history[i*DEPTH+1 +: DEPTH-1] == $past(history[i*DEPTH +: DEPTH-1])));
  end

endmodule

bind evt_occ_history evt_occ_history_chk #(
  .NX(NX), .DEPTH(DEPTH), .BIN_CYCLES(BIN_CYCLES)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .bin_done      (bin_done),
  .history_valid (history_valid),
  .history       (history)
);

// File: tb/evt_occ_history_bench.sv
module evt_occ_history_bench;

  localparam int NX    = 16;
  localparam int XW    = 8;
  localparam int DEPTH = 8;
  localparam int CNT_W = 8;
  localparam int THETA = 3;
  localparam int BIN   = 320;
  localparam int HW    = NX * DEPTH;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ev_valid = 1'b0;
  logic [XW-1:0] ev_pos = '0;
  logic          bin_done;
  logic          history_valid;
  logic [HW-1:0] history;

  int compared = 0;
  int mismatched = 0;
  int ecount = 0;
  string cur_req = "R10";

  always #2 clk = ~clk;

  evt_occ_history #(
    .NX(NX), .XW(XW), .DEPTH(DEPTH), .CNT_W(CNT_W),
    .THETA_E(THETA), .BIN_CYCLES(BIN)
  ) u_evt_occ_history (
    .clk           (clk),
    .rst           (rst),
    .ev_valid      (ev_valid),
    .ev_pos        (ev_pos),
    .bin_done      (bin_done),
    .history_valid (history_valid),
    .history       (history)
  );

  // Reference model built from the requirements
  int            mcnt [NX];
  logic [HW-1:0] exp_hist = '0;
  logic [HW-1:0] exp_q [$];
  logic          t0 = 0, t1 = 0, t2 = 0;

  always @(posedge clk) begin
    if (rst) begin
      ecount = 0;
      t0 = 0; t1 = 0; t2 = 0;
      for (int i = 0; i < NX; i++) mcnt[i] = 0;
    end else begin
      t2 = t1;
      t1 = t0;
      t0 = ((ecount % BIN) == BIN - 1);
      if (t0) begin
        for (int i = 0; i < NX; i++) begin
          exp_hist[i*DEPTH +: DEPTH] =
            {exp_hist[i*DEPTH +: DEPTH-1], (mcnt[i] >= THETA)};
          mcnt[i] = 0;
        end
        exp_q.push_back(exp_hist);
      end
      if (ev_valid && (int'(ev_pos) < NX) && mcnt[ev_pos] < 255)
        mcnt[ev_pos] = mcnt[ev_pos] + 1;
      ecount = ecount + 1;
    end
  end

  // Output monitor
  always @(negedge clk) begin
    if (rst) begin
      compared++;
      if (history !== '0 || bin_done !== 1'b0 || history_valid !== 1'b0) begin
        mismatched++;
        $display("FAIL R10 reset: hist=%h done=%b hv=%b expected 0/0/0",
                 history, bin_done, history_valid);
      end
    end else begin
      compared++;
      if (bin_done !== t0) begin
        mismatched++;
        $display("FAIL R1 bin_done=%b expected %b at edge %0d", bin_done, t0, ecount);
      end
      compared++;
      if (history_valid !== t2) begin
        mismatched++;
        $display("FAIL R9 history_valid=%b expected %b at edge %0d", history_valid, t2, ecount);
      end
      if (history_valid === 1'b1) begin
        logic [HW-1:0] e;
        compared++;
        if (exp_q.size() == 0) begin
          mismatched++;
          $display("FAIL %s history=%h expected none queued", cur_req, history);
        end else begin
          e = exp_q.pop_front();
          if (history !== e) begin
            mismatched++;
            $display("FAIL %s history=%h expected %h", cur_req, history, e);
          end
        end
      end
    end
  end

  task automatic align(int m);
    @(negedge clk);
    while ((ecount % BIN) != m) @(negedge clk);
  endtask

  task automatic drive(int p, int n);
    for (int k = 0; k < n; k++) begin
      ev_valid = 1'b1;
      ev_pos   = XW'(p);
      @(negedge clk);
    end
    ev_valid = 1'b0;
  endtask

  task automatic wait_hist();
    @(negedge clk);
    while (history_valid !== 1'b1) @(negedge clk);
  endtask

  task automatic finish_run();
    compared++;
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL R5 pending=%0d expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R2 / R3: distinct positions, at and below threshold, top position
    cur_req = "R3";
    align(2);
    drive(2, 3); drive(5, 2); drive(NX-1, 4); drive(0, 1); drive(7, 3);
    wait_hist();

    // R4: two sub-threshold bins must not sum
    cur_req = "R4";
    align(2); drive(3, 2); wait_hist();
    align(2); drive(3, 2); wait_hist();

    // R6: 256 hits, wrapping would give zero
    cur_req = "R6";
    align(2); drive(4, 256); wait_hist();

    // R8: out-of-range positions dropped, in-range one kept
    cur_req = "R8";
    align(2); drive(NX, 5); drive(200, 5); drive(255, 4); drive(1, 3);
    wait_hist();

    // R7: hits on the closing edge and the two processing cycles
    cur_req = "R7";
    align(BIN - 3);
    drive(9, 3);
    drive(9, 2);
    wait_hist();

    // R5 / R2: enough bins to push the oldest columns out
    cur_req = "R5";
    for (int b = 0; b < DEPTH + 2; b++) begin
      align(2);
      drive(b % NX, 3);
      drive((b * 5 + 1) % NX, b % 4);
      wait_hist();
    end

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule